// File: doc/BRIEF.md
# Dual-Issue In-Order Scoreboard Issue Unit

This block sits between a decoded-instruction queue and two execution lanes. Every cycle it looks at the two oldest queue entries (the head pair) and decides how many of them may start execution: none, one or both. The older entry always goes to lane 0 and the younger to lane 1. The unit reports the decision to the queue as a take count, so the queue can shift by that amount. The issued instructions appear on registered lane outputs in the following cycle.

Each entry carries an opcode, two optional source register indices, an optional destination index and a fixed result latency. Results are written only at the final execute stage and all lanes advance in order, so a write-after-read hazard cannot occur. The only check needed is read-after-write. A scoreboard holds, for each architectural register, a count of cycles until its pending value is ready. A source is usable when its count is zero. A second read-after-write check compares the younger entry's sources with the older entry's destination in the same pair.

A flush input, raised on a branch redirect or an exception, suppresses issue for that cycle, clears the lane outputs and marks every register ready. The queue itself discards its own contents on the same flush. The two issued instructions together read at most four registers, which stays within the six-read budget of the register file, so the read budget never limits issue.

Top module: `dual_issue_sb`

## Requirements
- R1: `take_cnt` is only ever 0, 1 or 2. Lane 1 issues only in a cycle where lane 0 also issues, so a stalled older entry also blocks the younger one.
- R2: The older entry issues when `h0_vld` is 1, `flush` is 0 and every enabled source has a scoreboard count of zero. When `h0_vld` is 0, `take_cnt` is 0 whatever the younger slot holds.
- R3: An entry with destination enabled and latency L≥1 that issues in cycle c makes that register unusable until cycle c+L. A consumer may issue in cycle c+L, and a latency of 1 therefore allows back-to-back issue. A latency of 0 behaves as 1.
- R4: If the younger entry has an enabled source (either source field) equal to the enabled destination of the older entry, only the older entry issues (`take_cnt`=1).
- R5: When a write is issued to a register that already has a pending value, the register becomes ready at the later of the two ready times.
- R6: While `flush` is 1, `take_cnt` is 0. In the next cycle both lane valids are 0 and every register is ready.
- R7: The lane outputs are registered. One cycle after a decision, `l0_vld`=(take≥1) and `l1_vld`=(take=2), and each issuing lane carries the opcode and register fields its head slot held.
- R8: While `rst_n` is 0, `take_cnt` is 0 and both lane valids are 0. After reset, every register is ready.
- R9: A source whose enable is 0 is neither checked against the scoreboard nor against the older destination. A destination whose enable is 0 does not update the scoreboard.
- R10: Register index 0 is tracked like every other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Redirect or exception: drop issue, clear scoreboard |
| h0_vld | input | 1 | Older head slot holds an instruction |
| h0_op | input | OP_W | Older opcode |
| h0_ra_en | input | 1 | Older source A used |
| h0_ra | input | log2(NREG) | Older source A index |
| h0_rb_en | input | 1 | Older source B used |
| h0_rb | input | log2(NREG) | Older source B index |
| h0_rd_en | input | 1 | Older destination used |
| h0_rd | input | log2(NREG) | Older destination index |
| h0_lat | input | LAT_W | Older result latency in cycles |
| h1_vld | input | 1 | Younger head slot holds an instruction |
| h1_op | input | OP_W | Younger opcode |
| h1_ra_en | input | 1 | Younger source A used |
| h1_ra | input | log2(NREG) | Younger source A index |
| h1_rb_en | input | 1 | Younger source B used |
| h1_rb | input | log2(NREG) | Younger source B index |
| h1_rd_en | input | 1 | Younger destination used |
| h1_rd | input | log2(NREG) | Younger destination index |
| h1_lat | input | LAT_W | Younger result latency in cycles |
| take_cnt | output | 2 | Entries issued this cycle (queue shift amount) |
| l0_vld | output | 1 | Lane 0 carries an issued instruction |
| l0_op | output | OP_W | Lane 0 opcode |
| l0_ra | output | log2(NREG) | Lane 0 source A index |
| l0_rb | output | log2(NREG) | Lane 0 source B index |
| l0_rd | output | log2(NREG) | Lane 0 destination index |
| l0_rd_en | output | 1 | Lane 0 destination used |
| l1_vld | output | 1 | Lane 1 carries an issued instruction |
| l1_op | output | OP_W | Lane 1 opcode |
| l1_ra | output | log2(NREG) | Lane 1 source A index |
| l1_rb | output | log2(NREG) | Lane 1 source B index |
| l1_rd | output | log2(NREG) | Lane 1 destination index |
| l1_rd_en | output | 1 | Lane 1 destination used |

## Verification
The assertions watch properties that hold on every cycle. These are the lane ordering (lane 1 never valid without lane 0), the legal take counts, the lane valids following the previous take count, the absence of any dual issue with an in-pair read-after-write, the silence during flush and idle heads, and the rule that a lane-0 producer with latency above one blocks a lane-0 consumer in the next cycle. Timing that spans several cycles can only be shown by the bench's sequences. This covers the exact cycle a consumer is released, the later-of-two ready time for overlapping writes, the clearing of pending counts by flush and reset, ignored enables, and register 0 behaving normally.

// File: rtl/issue_pkg.sv
// Shared types for the dual-issue scoreboard issue unit.
// Assumes: at most two instructions are taken per cycle.
package issue_pkg;

    // Number of head entries issued in one cycle (queue shift amount).
    typedef enum logic [1:0] {
        TAKE_NONE = 2'd0,
        TAKE_ONE  = 2'd1,
        TAKE_TWO  = 2'd2
    } take_e;

endpackage

// File: rtl/sb_table.sv
// Latency-predicting register scoreboard.
// Holds, per architectural register, the cycles left until its pending value
// is ready; zero means ready. Up to two writes are recorded per cycle, each
// keeping the later of the existing and the new ready time. Four read queries
// report readiness combinationally. Assumes NREG is a power of two.
module sb_table #(
    parameter int NREG  = 16,
    parameter int LAT_W = 3,
    localparam int RW   = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic [1:0]                wr_en,
    input  logic [1:0][RW-1:0]        wr_idx,
    input  logic [1:0][LAT_W-1:0]     wr_lat,
    input  logic [3:0][RW-1:0]        q_idx,
    output logic [3:0]                q_rdy
);

    logic [LAT_W-1:0] cnt [NREG];

    // Convert an issue latency into the count stored after the issue edge.
    function automatic logic [LAT_W-1:0] lat_to_cnt(input logic [LAT_W-1:0] l);
        return (l == '0) ? '0 : l - 1'b1;
    endfunction

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [LAT_W-1:0] nxt;

        // Next count: age the entry, then keep the latest pending write.
        always_comb begin
            nxt = (cnt[r] == '0) ? '0 : cnt[r] - 1'b1;
            for (int w = 0; w < 2; w++) begin
                if (wr_en[w] && (wr_idx[w] == RW'(r)) && (lat_to_cnt(wr_lat[w]) > nxt)) begin
                    nxt = lat_to_cnt(wr_lat[w]);
                end
            end
        end

        // Count register, cleared on reset or flush.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                cnt[r] <= '0;
            end else begin
                cnt[r] <= nxt;
            end
        end
    end

    for (genvar q = 0; q < 4; q++) begin : g_query
        assign q_rdy[q] = (cnt[q_idx[q]] == '0);
    end

endmodule

// File: rtl/pair_check.sv
// Issue decision for the head pair.
// Lane 0 issues when valid and its enabled sources are ready. Lane 1 issues
// only alongside lane 0, with its sources ready and none matching lane 0's
// enabled destination. Assumes q_rdy order {h1_rb, h1_ra, h0_rb, h0_ra}.
module pair_check #(
    parameter int RW = 4
) (
    input  logic          hold,
    input  logic          v0,
    input  logic          a0_en,
    input  logic          b0_en,
    input  logic          v1,
    input  logic          a1_en,
    input  logic          b1_en,
    input  logic [RW-1:0] a1,
    input  logic [RW-1:0] b1,
    input  logic          d0_en,
    input  logic [RW-1:0] d0,
    input  logic [3:0]    q_rdy,
    output logic          iss0,
    output logic          iss1
);

    logic src0_ok, src1_ok, pair_raw;

    // Per-slot source readiness and in-pair read-after-write detection.
    always_comb begin
        src0_ok  = (!a0_en || q_rdy[0]) && (!b0_en || q_rdy[1]);
        src1_ok  = (!a1_en || q_rdy[2]) && (!b1_en || q_rdy[3]);
        pair_raw = d0_en && ((a1_en && (a1 == d0)) || (b1_en && (b1 == d0)));
        iss0     = !hold && v0 && src0_ok;
        iss1     = iss0 && v1 && src1_ok && !pair_raw;
    end

endmodule

// File: rtl/lane_reg.sv
// Output register of one execution lane.
// Captures the head slot's fields when the slot issues; the valid bit drops
// on reset, flush or a cycle without issue.
module lane_reg #(
    parameter int OP_W = 8,
    parameter int RW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            iss,
    input  logic [OP_W-1:0] op,
    input  logic [RW-1:0]   ra,
    input  logic [RW-1:0]   rb,
    input  logic [RW-1:0]   rd,
    input  logic            rd_en,
    output logic            q_vld,
    output logic [OP_W-1:0] q_op,
    output logic [RW-1:0]   q_ra,
    output logic [RW-1:0]   q_rb,
    output logic [RW-1:0]   q_rd,
    output logic            q_rd_en
);

    // Lane valid register.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            q_vld <= 1'b0;
        end else begin
            q_vld <= iss;
        end
    end

    // Lane payload register, loaded only on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_op    <= '0;
            q_ra    <= '0;
            q_rb    <= '0;
            q_rd    <= '0;
            q_rd_en <= 1'b0;
        end else if (iss) begin
            q_op    <= op;
            q_ra    <= ra;
            q_rb    <= rb;
            q_rd    <= rd;
            q_rd_en <= rd_en;
        end
    end

endmodule

// File: rtl/dual_issue_sb.sv
// Dual-issue in-order issue unit with a latency-predicting scoreboard.
// Examines the two oldest queue entries, issues 0, 1 or 2 of them in order
// (older to lane 0), reports the count for the queue shift and registers the
// issued instructions onto the lane outputs. Assumes h1 is only meaningful
// when h0 is valid and that latencies fit LAT_W bits.
module dual_issue_sb #(
    parameter int NREG  = 16,
    parameter int OP_W  = 8,
    parameter int LAT_W = 3,
    localparam int RW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             h0_vld,
    input  logic [OP_W-1:0]  h0_op,
    input  logic             h0_ra_en,
    input  logic [RW-1:0]    h0_ra,
    input  logic             h0_rb_en,
    input  logic [RW-1:0]    h0_rb,
    input  logic             h0_rd_en,
    input  logic [RW-1:0]    h0_rd,
    input  logic [LAT_W-1:0] h0_lat,
    input  logic             h1_vld,
    input  logic [OP_W-1:0]  h1_op,
    input  logic             h1_ra_en,
    input  logic [RW-1:0]    h1_ra,
    input  logic             h1_rb_en,
    input  logic [RW-1:0]    h1_rb,
    input  logic             h1_rd_en,
    input  logic [RW-1:0]    h1_rd,
    input  logic [LAT_W-1:0] h1_lat,
    output logic [1:0]       take_cnt,
    output logic             l0_vld,
    output logic [OP_W-1:0]  l0_op,
    output logic [RW-1:0]    l0_ra,
    output logic [RW-1:0]    l0_rb,
    output logic [RW-1:0]    l0_rd,
    output logic             l0_rd_en,
    output logic             l1_vld,
    output logic [OP_W-1:0]  l1_op,
    output logic [RW-1:0]    l1_ra,
    output logic [RW-1:0]    l1_rb,
    output logic [RW-1:0]    l1_rd,
    output logic             l1_rd_en
);
    import issue_pkg::*;

    logic [3:0] src_rdy;
    logic       iss0, iss1;
    take_e      take;

    sb_table #(.NREG(NREG), .LAT_W(LAT_W)) u_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr_en  ({iss1 && h1_rd_en, iss0 && h0_rd_en}),
        .wr_idx ({h1_rd, h0_rd}),
        .wr_lat ({h1_lat, h0_lat}),
        .q_idx  ({h1_rb, h1_ra, h0_rb, h0_ra}),
        .q_rdy  (src_rdy)
    );

    pair_check #(.RW(RW)) u_pc (
        .hold  (flush || !rst_n),
        .v0    (h0_vld),
        .a0_en (h0_ra_en),
        .b0_en (h0_rb_en),
        .v1    (h1_vld),
        .a1_en (h1_ra_en),
        .b1_en (h1_rb_en),
        .a1    (h1_ra),
        .b1    (h1_rb),
        .d0_en (h0_rd_en),
        .d0    (h0_rd),
        .q_rdy (src_rdy),
        .iss0  (iss0),
        .iss1  (iss1)
    );

    // Encode the issue decision as the queue shift amount.
    always_comb begin
        if (iss1)      take = TAKE_TWO;
        else if (iss0) take = TAKE_ONE;
        else           take = TAKE_NONE;
    end
    assign take_cnt = take;

    lane_reg #(.OP_W(OP_W), .RW(RW)) u_lane0 (
        .clk (clk), .rst_n (rst_n), .flush (flush), .iss (iss0),
        .op (h0_op), .ra (h0_ra), .rb (h0_rb), .rd (h0_rd), .rd_en (h0_rd_en),
        .q_vld (l0_vld), .q_op (l0_op), .q_ra (l0_ra), .q_rb (l0_rb),
        .q_rd (l0_rd), .q_rd_en (l0_rd_en)
    );

    lane_reg #(.OP_W(OP_W), .RW(RW)) u_lane1 (
        .clk (clk), .rst_n (rst_n), .flush (flush), .iss (iss1),
        .op (h1_op), .ra (h1_ra), .rb (h1_rb), .rd (h1_rd), .rd_en (h1_rd_en),
        .q_vld (l1_vld), .q_op (l1_op), .q_ra (l1_ra), .q_rb (l1_rb),
        .q_rd (l1_rd), .q_rd_en (l1_rd_en)
    );

endmodule

// File: rtl/issue_chk.sv
// Property checker for dual_issue_sb, attached by bind.
// Observes the head inputs, the take count and the lane valids.
module issue_chk #(
    parameter int RW    = 4,
    parameter int LAT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             h0_vld,
    input logic             h0_ra_en,
    input logic [RW-1:0]    h0_ra,
    input logic             h0_rd_en,
    input logic [RW-1:0]    h0_rd,
    input logic [LAT_W-1:0] h0_lat,
    input logic             h1_ra_en,
    input logic [RW-1:0]    h1_ra,
    input logic             h1_rb_en,
    input logic [RW-1:0]    h1_rb,
    input logic [1:0]       take_cnt,
    input logic             l0_vld,
    input logic             l1_vld
);

    // R1
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l1_vld |-> l0_vld);

    // R1
    take_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_cnt != 2'd3);

    // R2
    idle_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !h0_vld |-> (take_cnt == 2'd0));

    // R3
    lat_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((take_cnt != 2'd0) && h0_rd_en && (h0_lat > LAT_W'(1)))
        |=> !((take_cnt != 2'd0) && h0_ra_en && (h0_ra == $past(h0_rd))));

    // R4
    pair_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((take_cnt == 2'd2) && h0_rd_en)
        |-> (!(h1_ra_en && (h1_ra == h0_rd)) && !(h1_rb_en && (h1_rb == h0_rd))));

    // R6
    flush_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (take_cnt == 2'd0));

    // R6
    flush_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!l0_vld && !l1_vld));

    // R7
    lane_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((l0_vld == ($past(take_cnt) != 2'd0)) && (l1_vld == ($past(take_cnt) == 2'd2))));

endmodule

bind dual_issue_sb issue_chk #(.RW($clog2(NREG)), .LAT_W(LAT_W)) u_issue_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .h0_vld   (h0_vld),
    .h0_ra_en (h0_ra_en),
    .h0_ra    (h0_ra),
    .h0_rd_en (h0_rd_en),
    .h0_rd    (h0_rd),
    .h0_lat   (h0_lat),
    .h1_ra_en (h1_ra_en),
    .h1_ra    (h1_ra),
    .h1_rb_en (h1_rb_en),
    .h1_rb    (h1_rb),
    .take_cnt (take_cnt),
    .l0_vld   (l0_vld),
    .l1_vld   (l1_vld)
);

// File: tb/test_dual_issue_sb.sv
// Self-checking bench for dual_issue_sb: a vector table walked one entry per
// cycle (scoreboard state carries across entries), then directed reset tests.
module test_dual_issue_sb;

    logic       clk = 1'b0;
    logic       rst_n, flush;
    logic       h0_vld, h0_ra_en, h0_rb_en, h0_rd_en;
    logic [7:0] h0_op;
    logic [3:0] h0_ra, h0_rb, h0_rd;
    logic [2:0] h0_lat;
    logic       h1_vld, h1_ra_en, h1_rb_en, h1_rd_en;
    logic [7:0] h1_op;
    logic [3:0] h1_ra, h1_rb, h1_rd;
    logic [2:0] h1_lat;
    logic [1:0] take_cnt;
    logic       l0_vld, l0_rd_en, l1_vld, l1_rd_en;
    logic [7:0] l0_op, l1_op;
    logic [3:0] l0_ra, l0_rb, l0_rd, l1_ra, l1_rb, l1_rd;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    dual_issue_sb i_dual_issue_sb (.*);

    // Slot encoding: {vld[18], ra_en[17], ra[16:13], rb_en[12], rb[11:8], rd_en[7], rd[6:3], lat[2:0]}
    function automatic logic [18:0] ins(bit v, bit ae, int a, bit be, int b, bit de, int d, int l);
        return {v, ae, 4'(a), be, 4'(b), de, 4'(d), 3'(l)};
    endfunction

    // Vector encoding: {older[40:22], younger[21:3], flush[2], expected take[1:0]}
    function automatic logic [40:0] vec(logic [18:0] o, logic [18:0] y, bit f, int t);
        return {o, y, f, 2'(t)};
    endfunction

    localparam logic [18:0] NOP = '0;
    localparam int NV = 20;
    localparam logic [40:0] VT [NV] = '{
        vec(ins(1,1,2,1,3,1,1,3), ins(1,1,5,0,0,1,4,1), 0, 2), // 0 R2 both free
        vec(ins(1,1,1,0,0,1,6,1), ins(1,1,6,0,0,0,0,1), 0, 0), // 1 R1 older stalls on r1
        vec(ins(1,1,1,0,0,1,6,1), ins(1,1,6,0,0,0,0,1), 0, 0), // 2 R3 still one cycle early
        vec(ins(1,1,1,0,0,1,7,2), ins(1,1,7,0,0,1,6,1), 0, 1), // 3 R3 released, R4 pair on ra
        vec(ins(1,1,7,0,0,1,6,1), NOP,                  0, 0), // 4 R3 lat 2 not yet
        vec(ins(1,1,7,0,0,1,0,1), NOP,                  0, 1), // 5 R10 write r0
        vec(ins(1,1,0,0,0,1,0,4), ins(1,0,0,0,0,1,8,2), 0, 2), // 6 R3 back-to-back, R9 disabled src
        vec(ins(1,1,0,0,0,1,2,1), NOP,                  0, 0), // 7 R10 r0 pending
        vec(ins(1,0,0,0,0,1,0,1), NOP,                  0, 1), // 8 R5 short write over long
        vec(ins(1,1,0,0,0,0,0,1), NOP,                  0, 0), // 9 R5 later time kept
        vec(ins(1,1,0,0,0,0,9,5), ins(1,1,9,0,0,1,3,1), 0, 2), // 10 R9 disabled dst
        vec(ins(1,1,9,0,0,1,10,4), NOP,                 0, 1), // 11 R9 r9 untouched
        vec(ins(1,0,0,0,0,1,11,1), NOP,                 1, 0), // 12 R6 flush
        vec(ins(1,1,10,0,0,1,12,2), ins(1,0,0,1,11,1,13,1), 0, 2), // 13 R6 r10 cleared
        vec(NOP, ins(1,0,0,0,0,1,14,1),                 0, 0), // 14 R2 idle older
        vec(ins(1,0,0,0,0,1,15,0), NOP,                 0, 1), // 15 R3 latency 0
        vec(ins(1,1,15,1,15,0,0,1), NOP,                0, 1), // 16 R3 lat 0 acts as 1
        vec(ins(1,0,0,0,0,1,5,1), ins(1,0,0,1,5,1,6,1), 0, 1), // 17 R4 pair on rb
        vec(ins(1,0,0,0,0,1,2,3), NOP,                  0, 1), // 18 R2 producer r2
        vec(ins(1,0,0,0,0,1,3,1), ins(1,1,2,0,0,1,4,1), 0, 1)  // 19 R1 younger waits alone
    };

    // Record one check; print a FAIL line on mismatch.
    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one head pair onto the inputs.
    task automatic drive(logic [18:0] o, logic [18:0] y, bit f, int idx);
        {h0_vld, h0_ra_en, h0_ra, h0_rb_en, h0_rb, h0_rd_en, h0_rd, h0_lat} = o;
        {h1_vld, h1_ra_en, h1_ra, h1_rb_en, h1_rb, h1_rd_en, h1_rd, h1_lat} = y;
        h0_op = 8'(idx);
        h1_op = 8'(idx + 64);
        flush = f;
    endtask

    // Check lane outputs one cycle after the decision for vector idx.
    task automatic chk_lanes(int idx, logic [40:0] v);
        int t;
        t = int'(v[1:0]);
        chk("R7", "l0_vld", int'(l0_vld), int'(t >= 1));
        chk("R1", "l1_vld", int'(l1_vld), int'(t == 2));
        if (t >= 1) begin
            chk("R7", "l0_op", int'(l0_op), idx);
            chk("R7", "l0_rd", int'(l0_rd), int'(v[28:25]));
        end
        if (t == 2) begin
            chk("R7", "l1_op", int'(l1_op), idx + 64);
            chk("R7", "l1_ra", int'(l1_ra), int'(v[19:16]));
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(ins(1,0,0,0,0,1,1,1), ins(1,0,0,0,0,1,2,1), 0, 0);
        repeat (2) @(negedge clk);
        #3;
        chk("R8", "take during reset", int'(take_cnt), 0);
        chk("R8", "l0_vld in reset", int'(l0_vld), 0);
        chk("R8", "l1_vld in reset", int'(l1_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: one vector per cycle.
        for (int i = 0; i < NV; i++) begin
            if (i > 0) chk_lanes(i - 1, VT[i - 1]);
            drive(VT[i][40:22], VT[i][21:3], VT[i][2], i);
            #3;
            chk($sformatf("R1/R2 vec%0d", i), "take_cnt", int'(take_cnt), int'(VT[i][1:0]));
            @(negedge clk);
        end
        chk_lanes(NV - 1, VT[NV - 1]);

        // R8: reset clears a pending long-latency write.
        drive(ins(1,0,0,0,0,1,13,7), NOP, 0, 100);
        #3;
        chk("R8", "producer take", int'(take_cnt), 1);
        @(negedge clk);
        drive(ins(1,1,13,0,0,0,0,1), NOP, 0, 101);
        #3;
        chk("R3", "consumer held by lat 7", int'(take_cnt), 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8", "l0_vld after reset", int'(l0_vld), 0);
        #3;
        chk("R8", "r13 ready after reset", int'(take_cnt), 1);
        @(negedge clk);
        chk("R7", "l0_op after reset issue", int'(l0_op), 101);

        // R6: flush right after an issue clears the lanes next cycle.
        drive(ins(1,0,0,0,0,1,4,6), ins(1,0,0,0,0,1,5,6), 0, 102);
        @(negedge clk);
        chk("R7", "l1_vld dual", int'(l1_vld), 1);
        drive(ins(1,1,4,1,5,0,0,1), NOP, 1, 103);
        #3;
        chk("R6", "take in flush", int'(take_cnt), 0);
        @(negedge clk);
        chk("R6", "l0_vld after flush", int'(l0_vld), 0);
        chk("R6", "l1_vld after flush", int'(l1_vld), 0);
        flush = 1'b0;
        #3;
        chk("R6", "r4 r5 ready after flush", int'(take_cnt), 1);
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule